// File: doc/BRIEF.md
# Compare-Match Up-Counter Timer

This block is a 32-bit up-counting timer reached through a small register window. Software selects one of three tick-enable inputs as the count source and programs a twelve-bit prescaler. It also sets a compare value. When the counter reaches that value, a sticky status flag is raised. If the matching interrupt enable is set, a level interrupt follows the flag.

The timer has two counting modes. In restart mode the counter falls back to zero on the tick after it reaches the compare value. In free-run mode it counts on past the match and wraps naturally at the top of its range. The crystal tick input passes through its own four-bit divider, which only works while a dedicated control bit is set. A wait-request input stops the counter unless software has allowed counting during wait.

Register writes take effect at the clock edge on which `bus_wr` is high. Reads are combinational: `bus_rdata` always shows the register selected by `bus_addr`. All tick inputs are single-cycle enables sampled at the clock edge.

Top module: `cmp_timer`

## Requirements
- R1: After reset every register (control 0x00, prescale 0x04, status 0x08, interrupt enable 0x0C, compare 0x10, counter 0x24) reads zero and `irq` is low.
- R2: Control bit 0 is the run enable. While it is clear, the counter reads zero and ignores ticks. Clearing it returns the counter and both divider states to zero.
- R3: Control bits 8:6 choose the source. Code 1 uses `tick_bus`, code 2 uses `tick_per`, and code 5 uses the divided crystal tick. Every other code produces no counts.
- R4: Prescale bits 11:0 hold N. The counter advances once for every N+1 selected ticks, and the divider state is kept between ticks.
- R5: Prescale bits 15:12 hold M. The crystal path gives one tick per M+1 `tick_xtal` pulses, but only while control bit 10 is set. With bit 10 clear, code 5 counts nothing.
- R6: With control bit 9 set (free run), the counter keeps incrementing after it equals the compare value.
- R7: With control bit 9 clear, the counter goes to zero on the next count after it equals the compare value.
- R8: Status bit 0 sets in the cycle the counter takes a value equal to the compare value. Writing 1 to it clears it, and writing 0 has no effect. A match in the same cycle as a clearing write leaves it set.
- R9: `irq` is high exactly when status bit 0 and interrupt-enable bit 0 are both set.
- R10: While `wait_req` is high, counting stops unless control bit 3 is set.
- R11: Control reads back bits 0, 3, 6-10 and prescale reads back bits 15:0, with all other bits zero. Compare reads back all 32 bits. Writes to the counter address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_bus | input | 1 | Bus-clock tick enable (source code 1) |
| tick_per | input | 1 | Peripheral-clock tick enable (source code 2) |
| tick_xtal | input | 1 | Crystal tick enable, divided by the crystal divider (source code 5) |
| wait_req | input | 1 | Wait-mode request |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Level interrupt |

## Verification
The in-line properties check, on every cycle, that the counter is zero while disabled and frozen during a blocked wait. They also check that it only steps by one or returns to zero, that the flag rises only with the counter on the compare value, and that illegal source codes never produce a tick. Only the bench scenarios can show the actual division ratios of both prescalers and the crystal-path gating. The same holds for the restart point, the write-one-clear priority against a concurrent match, the interrupt masking and the register read-back layout.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 6;
  localparam int PRE_W   = 12;
  localparam int XPRE_W  = 4;
  localparam int XPRE_LSB = PRE_W;

  localparam logic [ADDR_W-1:0] A_CTL  = 6'h00;
  localparam logic [ADDR_W-1:0] A_PRE  = 6'h04;
  localparam logic [ADDR_W-1:0] A_STAT = 6'h08;
  localparam logic [ADDR_W-1:0] A_IEN  = 6'h0C;
  localparam logic [ADDR_W-1:0] A_CMP  = 6'h10;
  localparam logic [ADDR_W-1:0] A_CNT  = 6'h24;

  localparam logic [2:0] SRC_BUS  = 3'd1;
  localparam logic [2:0] SRC_PER  = 3'd2;
  localparam logic [2:0] SRC_XTAL = 3'd5;

  typedef struct packed {
    logic       xtal_en;
    logic       free_run;
    logic [2:0] src;
    logic       wait_en;
    logic       en;
  } ctl_t;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              match,
  input  logic [CNT_W-1:0]  count,
  output ctl_t              ctl,
  output logic [PRE_W-1:0]  pre_main,
  output logic [XPRE_W-1:0] pre_xtal,
  output logic [CNT_W-1:0]  cmp,
  output logic              flag,
  output logic              ien,
  output logic [DATA_W-1:0] bus_rdata
);
  logic clr;
  assign clr = bus_wr && (bus_addr == A_STAT) && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl      <= '0;
      pre_main <= '0;
      pre_xtal <= '0;
      cmp      <= '0;
      ien      <= 1'b0;
      flag     <= 1'b0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          A_CTL: begin
            ctl.en       <= bus_wdata[0];
            ctl.wait_en  <= bus_wdata[3];
            ctl.src      <= bus_wdata[8:6];
            ctl.free_run <= bus_wdata[9];
            ctl.xtal_en  <= bus_wdata[10];
          end
          A_PRE: begin
            pre_main <= bus_wdata[PRE_W-1:0];
            pre_xtal <= bus_wdata[XPRE_LSB+XPRE_W-1:XPRE_LSB];
          end
          A_IEN:   ien <= bus_wdata[0];
          A_CMP:   cmp <= bus_wdata[CNT_W-1:0];
          default: ;
        endcase
      end
      // a fresh match outranks a clearing write
      flag <= match | (flag & ~clr);
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTL: begin
        bus_rdata[0]    = ctl.en;
        bus_rdata[3]    = ctl.wait_en;
        bus_rdata[8:6]  = ctl.src;
        bus_rdata[9]    = ctl.free_run;
        bus_rdata[10]   = ctl.xtal_en;
      end
      A_PRE: begin
        bus_rdata[PRE_W-1:0] = pre_main;
        bus_rdata[XPRE_LSB+XPRE_W-1:XPRE_LSB] = pre_xtal;
      end
      A_STAT:  bus_rdata[0] = flag;
      A_IEN:   bus_rdata[0] = ien;
      A_CMP:   bus_rdata[CNT_W-1:0] = cmp;
      A_CNT:   bus_rdata[CNT_W-1:0] = count;
      default: ;
    endcase
  end

  // R8: the flag can only rise on a match
  p_flag_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(match));
endmodule

// File: rtl/tmr_tick.sv
module tmr_tick
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              run,
  input  logic [2:0]        src,
  input  logic              xtal_en,
  input  logic [PRE_W-1:0]  pre_main,
  input  logic [XPRE_W-1:0] pre_xtal,
  input  logic              tick_bus,
  input  logic              tick_per,
  input  logic              tick_xtal,
  output logic              cnt_inc
);
  logic [XPRE_W-1:0] xcnt;
  logic [PRE_W-1:0]  pcnt;
  logic              xstep, xpulse, sel;

  assign xstep  = tick_xtal && xtal_en && (src == SRC_XTAL);
  assign xpulse = xstep && (xcnt == pre_xtal);

  always_comb begin
    case (src)
      SRC_BUS:  sel = tick_bus;
      SRC_PER:  sel = tick_per;
      SRC_XTAL: sel = xpulse;
      default:  sel = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      xcnt <= '0;
      pcnt <= '0;
    end else if (run) begin
      if (xstep) xcnt <= (xcnt == pre_xtal) ? '0 : xcnt + 1'b1;
      if (sel)   pcnt <= (pcnt == pre_main) ? '0 : pcnt + 1'b1;
    end
  end

  assign cnt_inc = run && sel && (pcnt == pre_main);

  // R3: unassigned source codes never yield a count
  p_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (src != SRC_BUS && src != SRC_PER && src != SRC_XTAL) |-> !cnt_inc);
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             blocked,
  input  logic             cnt_inc,
  input  logic             free_run,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] count,
  output logic             match
);
  logic [CNT_W-1:0] nxt;

  assign nxt   = (!free_run && count == cmp) ? '0 : count + 1'b1;
  assign match = cnt_inc && (nxt == cmp);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) count <= '0;
    else if (cnt_inc)  count <= nxt;
  end

  p_off_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (count == '0));
  p_wait_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && blocked) |=> $stable(count));
  // R6 / R7: only a unit step or a return to zero
  p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> (count == $past(count) + 1'b1 || count == '0));
  p_match_val_r8: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> (count == $past(cmp)));
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_bus,
  input  logic              tick_per,
  input  logic              tick_xtal,
  input  logic              wait_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  ctl_t              ctl;
  logic [PRE_W-1:0]  pre_main;
  logic [XPRE_W-1:0] pre_xtal;
  logic [CNT_W-1:0]  cmp, count;
  logic              flag, ien, match, cnt_inc, blocked, run;

  assign blocked = wait_req && !ctl.wait_en;
  assign run     = ctl.en && !blocked;

  tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .match(match), .count(count), .ctl(ctl),
    .pre_main(pre_main), .pre_xtal(pre_xtal), .cmp(cmp), .flag(flag),
    .ien(ien), .bus_rdata(bus_rdata)
  );

  tmr_tick u_tick (
    .clk(clk), .rst_n(rst_n), .en(ctl.en), .run(run), .src(ctl.src),
    .xtal_en(ctl.xtal_en), .pre_main(pre_main), .pre_xtal(pre_xtal),
    .tick_bus(tick_bus), .tick_per(tick_per), .tick_xtal(tick_xtal),
    .cnt_inc(cnt_inc)
  );

  tmr_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .en(ctl.en), .blocked(blocked),
    .cnt_inc(cnt_inc), .free_run(ctl.free_run), .cmp(cmp),
    .count(count), .match(match)
  );

  assign irq = flag & ien;
endmodule

// File: tb/sim_cmp_timer.sv
`timescale 1ns/1ps
module sim_cmp_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_bus = 0, tick_per = 0, tick_xtal = 0, wait_req = 0;
  logic        bus_wr = 0;
  logic [5:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];

  always #2.5 clk = ~clk;

  cmp_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_bus(tick_bus), .tick_per(tick_per),
    .tick_xtal(tick_xtal), .wait_req(wait_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq)
  );

  // monitor: consumes expected items away from the active edge
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = sbq.pop_front();
      act = it.is_irq ? {31'b0, irq} : bus_rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic rd_chk(input logic [5:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    bus_addr = a;
    it.is_irq = 0; it.exp = e; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
  endtask

  task automatic irq_chk(input bit e, input string tag);
    item_t it;
    @(posedge clk); #1;
    it.is_irq = 1; it.exp = {31'b0, e}; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  // which: 0 bus, 1 peripheral, 2 crystal
  task automatic pulse(input int which, input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      case (which)
        0: tick_bus = 1;
        1: tick_per = 1;
        default: tick_xtal = 1;
      endcase
      @(posedge clk); #1;
      tick_bus = 0; tick_per = 0; tick_xtal = 0;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    rd_chk(6'h00, 0, "R1 ctl");
    rd_chk(6'h04, 0, "R1 pre");
    rd_chk(6'h08, 0, "R1 stat");
    rd_chk(6'h0C, 0, "R1 ien");
    rd_chk(6'h10, 0, "R1 cmp");
    rd_chk(6'h24, 0, "R1 cnt");
    irq_chk(0, "R1 irq");

    // R11 register layout
    wr(6'h10, 32'hDEADBEEF); rd_chk(6'h10, 32'hDEADBEEF, "R11 cmp");
    wr(6'h04, 32'hFFFF7005); rd_chk(6'h04, 32'h00007005, "R11 pre");
    wr(6'h00, 32'h00000248); rd_chk(6'h00, 32'h00000248, "R11 ctl");
    wr(6'h00, 32'hFFFFF836); rd_chk(6'h00, 32'h00000000, "R11 ctl mask");
    wr(6'h24, 32'h12345678); rd_chk(6'h24, 0, "R11 cnt ro");
    wr(6'h04, 0);

    // R2 enable
    wr(6'h10, 32'h0000FFFF);
    wr(6'h00, 32'h240);
    pulse(0, 3); rd_chk(6'h24, 0, "R2 disabled");
    wr(6'h00, 32'h241);
    pulse(0, 5); rd_chk(6'h24, 5, "R2 enabled");
    wr(6'h00, 32'h240); rd_chk(6'h24, 0, "R2 cleared");

    // R3 source select
    wr(6'h00, 32'h281);
    pulse(0, 3); rd_chk(6'h24, 0, "R3 per ignores bus");
    pulse(1, 4); rd_chk(6'h24, 4, "R3 per counts");
    wr(6'h00, 32'h2C1);
    pulse(0, 2); pulse(1, 2); pulse(2, 2);
    rd_chk(6'h24, 4, "R3 code 3 idle");

    // R4 main prescaler
    wr(6'h00, 0);
    wr(6'h04, 2);
    wr(6'h00, 32'h241);
    pulse(0, 7); rd_chk(6'h24, 2, "R4 div3");
    pulse(0, 2); rd_chk(6'h24, 3, "R4 state kept");

    // R5 crystal path
    wr(6'h00, 0);
    wr(6'h04, 32'h3000);
    wr(6'h00, 32'h341);
    pulse(2, 8); rd_chk(6'h24, 0, "R5 gated off");
    wr(6'h00, 0);
    wr(6'h00, 32'h741);
    pulse(2, 8); rd_chk(6'h24, 2, "R5 div4");
    pulse(2, 3); rd_chk(6'h24, 2, "R5 partial");
    pulse(2, 1); rd_chk(6'h24, 3, "R5 complete");

    // R7 restart and R8 flag
    wr(6'h00, 0);
    wr(6'h04, 0);
    wr(6'h08, 1);
    wr(6'h10, 3);
    wr(6'h00, 32'h041);
    pulse(0, 3); rd_chk(6'h24, 3, "R7 at cmp");
    rd_chk(6'h08, 1, "R8 set on match");
    pulse(0, 1); rd_chk(6'h24, 0, "R7 restart");
    pulse(0, 2); rd_chk(6'h24, 2, "R7 after restart");
    wr(6'h08, 0); rd_chk(6'h08, 1, "R8 write0 no effect");
    wr(6'h08, 1); rd_chk(6'h08, 0, "R8 w1c");
    // match on the same edge as a clearing write
    @(posedge clk); #1;
    tick_bus = 1; bus_wr = 1; bus_addr = 6'h08; bus_wdata = 1;
    @(posedge clk); #1;
    tick_bus = 0; bus_wr = 0;
    rd_chk(6'h08, 1, "R8 set beats clear");

    // R9 interrupt masking
    irq_chk(0, "R9 masked");
    wr(6'h0C, 1); irq_chk(1, "R9 enabled");
    wr(6'h08, 1); irq_chk(0, "R9 after clear");

    // R6 free run
    wr(6'h00, 0);
    wr(6'h10, 2);
    wr(6'h00, 32'h241);
    pulse(0, 5); rd_chk(6'h24, 5, "R6 past cmp");
    rd_chk(6'h08, 1, "R6 flag");
    irq_chk(1, "R9 irq free run");

    // R10 wait
    wait_req = 1;
    pulse(0, 3); rd_chk(6'h24, 5, "R10 stalled");
    wr(6'h00, 32'h249);
    pulse(0, 3); rd_chk(6'h24, 8, "R10 wait allowed");
    wait_req = 0;

    repeat (2) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule